// File: doc/BRIEF.md
# Period Timer with Capture Control

This block is an up-counting timer built around a power-of-two prescaler, a period register, a capture register, one configuration register and one control/status register. Software reaches all of them through a small register port: writes take effect at the next clock edge, and reads are combinational. The counter advances while the timer is enabled and running. It flags the step that lands on the period value and the return to zero. It can either freeze at the period value or keep counting past it.

An external reset/start input can hold the count at zero while it is high (level mode), or it can start and restart the count on each rising edge (edge mode). An external capture input copies the count on a rising edge. Software commands clear the count and take a capture. Each command bit clears itself once the action is done. When the timer clock is stopped, either because the enable is off or because the debug freeze input is high, a synchronization bit decides whether a pending command runs at once or waits for the clock to resume.

Three sticky flags (period, zero, capture) drive three interrupt outputs through per-flag enables. One-shot mode turns the enable off when the period is reached.

Top module: `period_timer`

## Requirements
- R1: After reset, the control/status register (address 0), the count (address 3) and the capture register (address 4) read 0, the period register (address 2) reads all ones, and all three interrupt outputs are low.
- R2: The configuration register (address 1) holds the following fields: enable in bit 0, prescale select N in bits 3:1, external mode in bits 5:4, sync in bit 6, and the period/zero/capture interrupt enables in bits 7/8/9. The count steps by one every 2^N clock cycles while the timer runs, and the first step comes 2^N cycles after the enable is written.
- R3: The period flag (status bit 5) sets only when the counter steps from PR-1 to PR. Loading a value, including PR itself, through the count register (address 3) never sets it.
- R4: With limit (status bit 2) set, a count equal to PR holds and raises no further flags. With limit clear, the count goes on to PR+1 and wraps from all ones to zero.
- R5: The zero flag (status bit 6) sets on a wrap to zero, on an executed clear command, and on an external restart or hold-start edge while the timer is enabled.
- R6: With one-shot (status bit 1) set, reaching PR clears the enable bit and the count stays at PR. With one-shot clear, edge mode can restart the count any number of times.
- R7: In external mode 01 (level), a high reset/start input holds the count at zero and the run bit (status bit 0) reads 0. In external mode 10 (edge), the count stays idle until a rising edge, and each rising edge reloads zero. In mode 00 the input is ignored.
- R8: Writing 1 to the clear command (status bit 3) zeroes the count and the prescaler, and the bit then clears itself. The capture register is unchanged, and a clear beats a count step in the same cycle. Writing 0 has no effect.
- R9: Writing 1 to the capture command (status bit 4) copies the count into the capture register one cycle later, and the bit then clears itself. A rising edge on the external capture input while the timer is counting also captures. Writing 0 has no effect.
- R10: The capture flag (status bit 7) sets on a capture only while the run bit is 1.
- R11: While the timer clock is stopped (enable 0 or freeze high), a pending clear or capture command executes at the next edge if sync is 0. If sync is 1, it stays pending until the clock runs.
- R12: Flags are sticky and set whether or not their interrupt is enabled. A status write sets or clears them, a hardware set beats a software clear, and each interrupt output is its flag AND its enable.
- R13: The run bit is read-only. It reads 1 only when the timer is enabled and not held or waiting on the external reset/start input.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| freeze_i | input | 1 | Debug freeze; stops the timer clock |
| ext_rst_i | input | 1 | External reset/start input |
| ext_cap_i | input | 1 | External capture input |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 3 | Register write address |
| wr_data_i | input | 16 | Register write data |
| rd_addr_i | input | 3 | Register read address |
| rd_data_o | output | 16 | Register read data (combinational) |
| irq_period_o | output | 1 | Period interrupt request |
| irq_zero_o | output | 1 | Zero interrupt request |
| irq_capture_o | output | 1 | Capture interrupt request |

## Verification
The assertions check the following on every cycle:
- a rising period flag always coincides with a count equal to PR;
- a limited count at PR never moves;
- one-shot drops the enable only at PR;
- commands self-clear when allowed to run and stay pending while the clock is stopped under sync;
- the capture flag cannot rise while the timer is not running.

The exact arithmetic of the count under each prescale setting, the capture values, the restart sequences of the two external modes and the flag-to-interrupt gating are shown only by the bench's directed sweeps on an 8-bit counter.

// File: rtl/ptmr_pkg.sv
package ptmr_pkg;

    // register addresses
    localparam logic [2:0] ADR_CSR = 3'd0;
    localparam logic [2:0] ADR_CFG = 3'd1;
    localparam logic [2:0] ADR_PER = 3'd2;
    localparam logic [2:0] ADR_CNT = 3'd3;
    localparam logic [2:0] ADR_CAP = 3'd4;

    // control/status bit positions
    localparam int CSR_RUN  = 0;
    localparam int CSR_ONE  = 1;
    localparam int CSR_LIM  = 2;
    localparam int CSR_CLR  = 3;
    localparam int CSR_CAPT = 4;
    localparam int CSR_PERF = 5;
    localparam int CSR_ZERF = 6;
    localparam int CSR_CAPF = 7;

    typedef enum logic [1:0] {
        EXT_NONE  = 2'b00,
        EXT_LEVEL = 2'b01,
        EXT_EDGE  = 2'b10,
        EXT_RSVD  = 2'b11
    } ext_mode_e;

endpackage

// File: rtl/ptmr_edge_det.sv
module ptmr_edge_det (
    input  logic clk,
    input  logic rst_n,
    input  logic d_i,
    output logic rise_o
);
    logic prev_d, prev_q;

    always_comb begin
        prev_d = d_i;
        rise_o = d_i & ~prev_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) prev_q <= 1'b0;
        else        prev_q <= prev_d;
    end
endmodule

// File: rtl/ptmr_prescaler.sv
module ptmr_prescaler #(
    parameter int SEL_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en_i,
    input  logic             clr_i,
    input  logic [SEL_W-1:0] sel_i,
    output logic             tick_o
);
    localparam int PS_W = (1 << SEL_W) - 1;

    logic [PS_W-1:0] pre_d, pre_q;
    logic [PS_W-1:0] mask;

    always_comb begin
        mask   = ~({PS_W{1'b1}} << sel_i);
        tick_o = en_i & ((pre_q & mask) == mask);
        pre_d  = pre_q;
        if (clr_i)       pre_d = '0;
        else if (tick_o) pre_d = '0;
        else if (en_i)   pre_d = pre_q + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pre_q <= '0;
        else        pre_q <= pre_d;
    end
endmodule

// File: rtl/period_timer.sv
module period_timer
    import ptmr_pkg::*;
#(
    parameter int CNT_W    = 16,
    parameter int PS_SEL_W = 3,
    parameter int DATA_W   = 16,
    parameter int ADDR_W   = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              freeze_i,
    input  logic              ext_rst_i,
    input  logic              ext_cap_i,
    input  logic              wr_en_i,
    input  logic [ADDR_W-1:0] wr_addr_i,
    input  logic [DATA_W-1:0] wr_data_i,
    input  logic [ADDR_W-1:0] rd_addr_i,
    output logic [DATA_W-1:0] rd_data_o,
    output logic              irq_period_o,
    output logic              irq_zero_o,
    output logic              irq_capture_o
);
    // configuration field positions, derived from the prescale select width
    localparam int CFG_ON   = 0;
    localparam int CFG_PS   = 1;
    localparam int CFG_MODE = CFG_PS + PS_SEL_W;
    localparam int CFG_SYNC = CFG_MODE + 2;
    localparam int CFG_IE   = CFG_SYNC + 1;
    localparam int N_EXT    = 2;

    typedef struct packed {
        logic                on;
        logic [PS_SEL_W-1:0] ps_sel;
        ext_mode_e           mode;
        logic                sync;
        logic [2:0]          ie;       // [0] period, [1] zero, [2] capture
        logic                oneshot;
        logic                limit;
        logic                clr_p;
        logic                capt_p;
        logic                f_per;
        logic                f_zer;
        logic                f_cap;
        logic                started;
        logic [CNT_W-1:0]    pr;
        logic [CNT_W-1:0]    cnt;
        logic [CNT_W-1:0]    cap;
    } st_t;

    st_t st_d, st_q;

    // edge detection on the two external inputs
    logic [N_EXT-1:0] ext_in, ext_rise;
    assign ext_in = {ext_cap_i, ext_rst_i};

    for (genvar g = 0; g < N_EXT; g++) begin : g_edge
        ptmr_edge_det u_edge (
            .clk    (clk),
            .rst_n  (rst_n),
            .d_i    (ext_in[g]),
            .rise_o (ext_rise[g])
        );
    end

    logic rst_rise, cap_rise;
    assign rst_rise = ext_rise[0];
    assign cap_rise = ext_rise[1];

    // decoded control
    logic is_lvl, is_edg;
    logic tclk_en, exec_ok, clr_exec, capt_exec;
    logic run, counting, ext_zero, ext_zero_evt;
    logic tick, limited, stop;
    logic csr_wr, cfg_wr, pr_wr, cnt_wr;
    logic per_evt, wrap_evt, zer_evt, cap_evt, capf_evt;
    logic [CNT_W-1:0] inc;

    always_comb begin
        is_lvl    = (st_q.mode == EXT_LEVEL);
        is_edg    = (st_q.mode == EXT_EDGE);
        tclk_en   = st_q.on & ~freeze_i;
        exec_ok   = tclk_en | ~st_q.sync;
        clr_exec  = st_q.clr_p & exec_ok;
        capt_exec = st_q.capt_p & exec_ok;

        if (is_lvl)      run = st_q.on & ~ext_rst_i;
        else if (is_edg) run = st_q.on & st_q.started;
        else             run = st_q.on;
        counting = run & ~freeze_i;

        ext_zero     = tclk_en & ((is_lvl & ext_rst_i) | (is_edg & rst_rise));
        ext_zero_evt = tclk_en & (is_lvl | is_edg) & rst_rise;

        csr_wr = wr_en_i & (wr_addr_i == ADR_CSR);
        cfg_wr = wr_en_i & (wr_addr_i == ADR_CFG);
        pr_wr  = wr_en_i & (wr_addr_i == ADR_PER);
        cnt_wr = wr_en_i & (wr_addr_i == ADR_CNT);
    end

    ptmr_prescaler #(.SEL_W(PS_SEL_W)) u_pre (
        .clk    (clk),
        .rst_n  (rst_n),
        .en_i   (counting),
        .clr_i  (clr_exec | ext_zero),
        .sel_i  (st_q.ps_sel),
        .tick_o (tick)
    );

    // event decode: a step counts only if nothing of higher priority overrides it
    always_comb begin
        inc      = st_q.cnt + 1'b1;
        limited  = st_q.limit & (st_q.cnt == st_q.pr);
        per_evt  = tick & ~limited & ~clr_exec & ~ext_zero & ~cnt_wr & (inc == st_q.pr);
        wrap_evt = tick & ~limited & ~clr_exec & ~ext_zero & ~cnt_wr & (inc == '0);
        zer_evt  = clr_exec | ext_zero_evt | wrap_evt;
        cap_evt  = capt_exec | (cap_rise & counting);
        capf_evt = cap_evt & run;
        stop     = per_evt & st_q.oneshot;
    end

    // next-state computation
    always_comb begin
        st_d = st_q;

        // configuration register
        if (cfg_wr) begin
            st_d.on     = wr_data_i[CFG_ON];
            st_d.ps_sel = wr_data_i[CFG_PS +: PS_SEL_W];
            st_d.mode   = ext_mode_e'(wr_data_i[CFG_MODE +: 2]);
            st_d.sync   = wr_data_i[CFG_SYNC];
            st_d.ie     = wr_data_i[CFG_IE +: 3];
        end
        if (stop) st_d.on = 1'b0;

        // edge-mode start latch, cleared whenever the timer is disabled
        if (!st_q.on)                           st_d.started = 1'b0;
        else if (is_edg && rst_rise && tclk_en) st_d.started = 1'b1;

        // period register
        if (pr_wr) st_d.pr = wr_data_i[CNT_W-1:0];

        // counter, in priority order
        if (clr_exec)                st_d.cnt = '0;
        else if (ext_zero)           st_d.cnt = '0;
        else if (cnt_wr)             st_d.cnt = wr_data_i[CNT_W-1:0];
        else if (tick && !limited)   st_d.cnt = inc;

        // capture register
        if (cap_evt) st_d.cap = st_q.cnt;

        // mode bits and self-clearing commands
        if (csr_wr) begin
            st_d.oneshot = wr_data_i[CSR_ONE];
            st_d.limit   = wr_data_i[CSR_LIM];
        end
        st_d.clr_p  = (st_q.clr_p & ~clr_exec) | (csr_wr & wr_data_i[CSR_CLR]);
        st_d.capt_p = (st_q.capt_p & ~capt_exec) | (csr_wr & wr_data_i[CSR_CAPT]);

        // sticky flags: software write, hardware set has priority
        if (csr_wr) begin
            st_d.f_per = wr_data_i[CSR_PERF];
            st_d.f_zer = wr_data_i[CSR_ZERF];
            st_d.f_cap = wr_data_i[CSR_CAPF];
        end
        if (per_evt)  st_d.f_per = 1'b1;
        if (zer_evt)  st_d.f_zer = 1'b1;
        if (capf_evt) st_d.f_cap = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q    <= '0;
            st_q.pr <= '1;
        end else begin
            st_q <= st_d;
        end
    end

    // read mux and interrupt outputs
    always_comb begin
        rd_data_o = '0;
        case (rd_addr_i)
            ADR_CSR: begin
                rd_data_o[CSR_RUN]  = run;
                rd_data_o[CSR_ONE]  = st_q.oneshot;
                rd_data_o[CSR_LIM]  = st_q.limit;
                rd_data_o[CSR_CLR]  = st_q.clr_p;
                rd_data_o[CSR_CAPT] = st_q.capt_p;
                rd_data_o[CSR_PERF] = st_q.f_per;
                rd_data_o[CSR_ZERF] = st_q.f_zer;
                rd_data_o[CSR_CAPF] = st_q.f_cap;
            end
            ADR_CFG: begin
                rd_data_o[CFG_ON]               = st_q.on;
                rd_data_o[CFG_PS +: PS_SEL_W]   = st_q.ps_sel;
                rd_data_o[CFG_MODE +: 2]        = st_q.mode;
                rd_data_o[CFG_SYNC]             = st_q.sync;
                rd_data_o[CFG_IE +: 3]          = st_q.ie;
            end
            ADR_PER: rd_data_o = DATA_W'(st_q.pr);
            ADR_CNT: rd_data_o = DATA_W'(st_q.cnt);
            ADR_CAP: rd_data_o = DATA_W'(st_q.cap);
            default: rd_data_o = '0;
        endcase

        irq_period_o  = st_q.f_per & st_q.ie[0];
        irq_zero_o    = st_q.f_zer & st_q.ie[1];
        irq_capture_o = st_q.f_cap & st_q.ie[2];
    end
endmodule

// File: rtl/ptmr_checker.sv
module ptmr_checker
    import ptmr_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic             wr_en,
    input logic             ext_rst,
    input logic             run,
    input logic             exec_ok,
    input logic             clr_exec,
    input logic             ext_zero,
    input logic             per_evt,
    input logic             on,
    input logic             oneshot,
    input logic             limit,
    input ext_mode_e        mode,
    input logic             clr_p,
    input logic             capt_p,
    input logic             f_per,
    input logic             f_cap,
    input logic [CNT_W-1:0] cnt,
    input logic [CNT_W-1:0] pr
);
    // R3
    per_flag_at_pr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!f_per && !wr_en) |=> (!f_per || cnt == pr));

    // R4
    limit_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (limit && cnt == pr && !wr_en && !clr_exec && !ext_zero) |=> $stable(cnt));

    // R6
    oneshot_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (oneshot && on && !wr_en) |=> (on || cnt == pr));

    // R7
    level_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == EXT_LEVEL && ext_rst) |-> !run);

    // R8
    clr_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        clr_exec |=> cnt == '0);

    // R8
    clr_selfclear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_p && exec_ok && !wr_en) |=> !clr_p);

    // R9
    capt_selfclear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (capt_p && exec_ok && !wr_en) |=> !capt_p);

    // R10
    capf_needs_run_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!f_cap && !wr_en && !run) |=> !f_cap);

    // R11
    sync_wait_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_p && !exec_ok && !wr_en) |=> (clr_p && $stable(cnt)));

    // R12
    hw_set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        per_evt |=> f_per);
endmodule

bind period_timer ptmr_checker #(.CNT_W(CNT_W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (wr_en_i),
    .ext_rst  (ext_rst_i),
    .run      (run),
    .exec_ok  (exec_ok),
    .clr_exec (clr_exec),
    .ext_zero (ext_zero),
    .per_evt  (per_evt),
    .on       (st_q.on),
    .oneshot  (st_q.oneshot),
    .limit    (st_q.limit),
    .mode     (st_q.mode),
    .clr_p    (st_q.clr_p),
    .capt_p   (st_q.capt_p),
    .f_per    (st_q.f_per),
    .f_cap    (st_q.f_cap),
    .cnt      (st_q.cnt),
    .pr       (st_q.pr)
);

// File: tb/tb_period_timer.sv
`timescale 1ns/1ps
module tb_period_timer;
    localparam int W = 8;
    // addresses
    localparam logic [2:0] A_CSR = 3'd0, A_CFG = 3'd1, A_PER = 3'd2, A_CNT = 3'd3, A_CAP = 3'd4;
    // status bits
    localparam int B_RUN = 0, B_ONE = 1, B_LIM = 2, B_CLR = 3, B_CAPT = 4;
    localparam int B_PERF = 5, B_ZERF = 6, B_CAPF = 7;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        freeze = 1'b0, ext_rst = 1'b0, ext_cap = 1'b0;
    logic        wr_en = 1'b0;
    logic [2:0]  wr_addr = '0, rd_addr = '0;
    logic [15:0] wr_data = '0;
    logic [15:0] rd_data;
    logic        irq_per, irq_zer, irq_cap;

    int n_chk = 0;
    int n_fail = 0;

    always #2.5 clk = ~clk;

    period_timer #(.CNT_W(W)) dut (
        .clk(clk), .rst_n(rst_n), .freeze_i(freeze), .ext_rst_i(ext_rst), .ext_cap_i(ext_cap),
        .wr_en_i(wr_en), .wr_addr_i(wr_addr), .wr_data_i(wr_data), .rd_addr_i(rd_addr),
        .rd_data_o(rd_data), .irq_period_o(irq_per), .irq_zero_o(irq_zer), .irq_capture_o(irq_cap)
    );

    task automatic chk(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr(input logic [2:0] a, input int d);
        wr_addr = a; wr_data = 16'(d); wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output int v);
        rd_addr = a;
        #1;
        v = int'(rd_data);
    endtask

    function automatic int cfg(input int on, input int ps, input int mode, input int sync, input int ie);
        return on | (ps << 1) | (mode << 4) | (sync << 6) | (ie << 7);
    endfunction

    function automatic int csr(input int one, input int lim);
        return (one << B_ONE) | (lim << B_LIM);
    endfunction

    // stop, program, clear count and prescaler, then clear flags
    task automatic prep(input int ps, input int mode, input int pr, input int lim, input int one);
        wr(A_CFG, cfg(0, ps, mode, 0, 0));
        wr(A_PER, pr);
        wr(A_CSR, csr(one, lim) | (1 << B_CLR));
        idle(1);
        wr(A_CSR, csr(one, lim));
    endtask

    task automatic summary;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    endtask

    initial begin
        #(5.0 * 150000);
        n_fail++;
        $display("FAIL watchdog: actual 1 expected 0");
        summary();
        $finish;
    end

    initial begin
        int v;
        idle(2);
        rst_n = 1'b1;
        idle(1);

        // R1 reset state
        rd(A_CSR, v); chk("R1 csr", v, 0);
        rd(A_CNT, v); chk("R1 count", v, 0);
        rd(A_CAP, v); chk("R1 capture", v, 0);
        rd(A_PER, v); chk("R1 period", v, 255);
        chk("R1 irqs", int'({irq_per, irq_zer, irq_cap}), 0);

        // R2 R3 prescaler sweep with period 6
        for (int ps = 0; ps < 4; ps++) begin
            for (int ki = 0; ki < 5; ki++) begin
                int k;
                k = (ki == 0) ? 0 : (ki == 1) ? 3 : (ki == 2) ? 7 : (ki == 3) ? 13 : 20;
                prep(ps, 0, 6, 0, 0);
                wr(A_CFG, cfg(1, ps, 0, 0, 0));
                idle(k);
                rd(A_CNT, v); chk($sformatf("R2 count ps=%0d k=%0d", ps, k), v, k >> ps);
                rd(A_CSR, v);
                chk($sformatf("R3 period flag ps=%0d k=%0d", ps, k), (v >> B_PERF) & 1, ((k >> ps) >= 6) ? 1 : 0);
                chk("R5 no zero flag", (v >> B_ZERF) & 1, 0);
                chk("R13 run bit", v & 1, 1);
            end
        end

        // R4 limit sweep
        for (int pi = 0; pi < 2; pi++) begin
            for (int ki = 0; ki < 3; ki++) begin
                int pr, k;
                pr = (pi == 0) ? 3 : 9;
                k  = (ki == 0) ? 2 : (ki == 1) ? 9 : 15;
                prep(0, 0, pr, 1, 0);
                wr(A_CFG, cfg(1, 0, 0, 0, 0));
                idle(k);
                rd(A_CNT, v); chk($sformatf("R4 limited count pr=%0d k=%0d", pr, k), v, (k < pr) ? k : pr);
                rd(A_CSR, v); chk("R4 limited flag", (v >> B_PERF) & 1, (k >= pr) ? 1 : 0);
                if (k == 15) begin
                    wr(A_CSR, csr(0, 1));
                    idle(4);
                    rd(A_CSR, v); chk("R4 no further period flag", (v >> B_PERF) & 1, 0);
                    rd(A_CNT, v); chk("R4 still at period", v, pr);
                end
            end
        end

        // R4 R5 R12 wrap, flags set with interrupts disabled
        prep(0, 0, 200, 0, 0);
        wr(A_CNT, 250);
        wr(A_CFG, cfg(1, 0, 0, 0, 0));
        idle(6);
        rd(A_CNT, v); chk("R4 wrap count", v, 0);
        rd(A_CSR, v); chk("R5 zero flag on wrap", (v >> B_ZERF) & 1, 1);
        chk("R12 irq disabled", int'(irq_zer), 0);
        wr(A_CFG, cfg(1, 0, 0, 0, 2));
        chk("R12 irq enabled", int'(irq_zer), 1);
        // R3 direct load of PR, then PR+1
        wr(A_CNT, 200);
        rd(A_CNT, v); chk("R3 loaded count", v, 200);
        rd(A_CSR, v); chk("R3 no flag on load", (v >> B_PERF) & 1, 0);
        idle(3);
        rd(A_CNT, v); chk("R4 past period", v, 203);
        rd(A_CSR, v); chk("R3 still no flag", (v >> B_PERF) & 1, 0);

        // R6 one-shot
        prep(0, 0, 4, 0, 1);
        wr(A_CFG, cfg(1, 0, 0, 0, 0));
        idle(10);
        rd(A_CNT, v); chk("R6 one-shot count", v, 4);
        rd(A_CFG, v); chk("R6 enable cleared", v & 1, 0);
        rd(A_CSR, v); chk("R13 run after one-shot", v & 1, 0);

        // R7 level mode
        ext_rst = 1'b1;
        prep(0, 1, 255, 0, 0);
        wr(A_CFG, cfg(1, 0, 1, 0, 0));
        idle(4);
        rd(A_CNT, v); chk("R7 level held count", v, 0);
        rd(A_CSR, v); chk("R7 level run bit", v & 1, 0);
        ext_rst = 1'b0;
        idle(5);
        rd(A_CNT, v); chk("R7 level released count", v, 5);
        rd(A_CSR, v); chk("R13 run when released", v & 1, 1);
        ext_rst = 1'b1;
        idle(2);
        rd(A_CNT, v); chk("R7 level re-held", v, 0);
        rd(A_CSR, v); chk("R5 zero flag on hold", (v >> B_ZERF) & 1, 1);
        ext_rst = 1'b0;

        // R6 R7 edge mode with repeated restarts
        prep(0, 2, 255, 0, 0);
        wr(A_CFG, cfg(1, 0, 2, 0, 0));
        idle(3);
        rd(A_CNT, v); chk("R7 edge waiting count", v, 0);
        rd(A_CSR, v); chk("R7 edge waiting run", v & 1, 0);
        ext_rst = 1'b1;
        idle(5);
        rd(A_CNT, v); chk("R7 edge started count", v, 4);
        rd(A_CSR, v); chk("R5 zero flag on start", (v >> B_ZERF) & 1, 1);
        ext_rst = 1'b0;
        idle(2);
        rd(A_CNT, v); chk("R7 edge running", v, 6);
        ext_rst = 1'b1;
        idle(3);
        rd(A_CNT, v); chk("R6 restart again", v, 2);
        ext_rst = 1'b0;

        // R9 R10 capture while stopped, R8 write of zero
        prep(0, 0, 255, 0, 0);
        wr(A_CNT, 37);
        wr(A_CSR, 1 << B_CAPT);
        rd(A_CSR, v); chk("R9 capt pending", (v >> B_CAPT) & 1, 1);
        idle(1);
        rd(A_CSR, v); chk("R9 capt self-cleared", (v >> B_CAPT) & 1, 0);
        chk("R10 no flag when stopped", (v >> B_CAPF) & 1, 0);
        rd(A_CAP, v); chk("R9 stopped capture", v, 37);
        wr(A_CSR, 0);
        idle(1);
        rd(A_CNT, v); chk("R8 write zero no effect", v, 37);

        // R9 R10 capture while running
        prep(0, 0, 255, 0, 0);
        wr(A_CFG, cfg(1, 0, 0, 0, 4));
        idle(5);
        wr(A_CSR, 1 << B_CAPT);
        idle(1);
        rd(A_CAP, v); chk("R9 command capture", v, 6);
        rd(A_CSR, v); chk("R10 flag when running", (v >> B_CAPF) & 1, 1);
        chk("R12 capture irq", int'(irq_cap), 1);
        ext_cap = 1'b1;
        idle(1);
        ext_cap = 1'b0;
        rd(A_CAP, v); chk("R9 external capture", v, 7);
        wr(A_CFG, cfg(0, 0, 0, 0, 0));
        ext_cap = 1'b1;
        idle(2);
        ext_cap = 1'b0;
        rd(A_CAP, v); chk("R9 no external capture when stopped", v, 7);

        // R8 clear while running with prescale 4
        prep(2, 0, 255, 0, 0);
        wr(A_CFG, cfg(1, 2, 0, 0, 0));
        idle(10);
        rd(A_CNT, v); chk("R2 before clear", v, 2);
        wr(A_CSR, 1 << B_CLR);
        idle(1);
        rd(A_CNT, v); chk("R8 cleared", v, 0);
        rd(A_CSR, v); chk("R5 zero flag on clear", (v >> B_ZERF) & 1, 1);
        idle(3);
        rd(A_CNT, v); chk("R8 prescaler cleared", v, 0);
        idle(1);
        rd(A_CNT, v); chk("R8 first step after clear", v, 1);
        rd(A_CAP, v); chk("R8 capture unchanged", v, 7);

        // R11 sync=1 with enable off
        prep(0, 0, 255, 0, 0);
        wr(A_CNT, 20);
        wr(A_CFG, cfg(0, 0, 0, 1, 0));
        wr(A_CSR, 1 << B_CLR);
        idle(3);
        rd(A_CSR, v); chk("R11 clear waits", (v >> B_CLR) & 1, 1);
        rd(A_CNT, v); chk("R11 count kept", v, 20);
        wr(A_CFG, cfg(1, 0, 0, 1, 0));
        idle(1);
        rd(A_CNT, v); chk("R11 clear on resume", v, 0);
        rd(A_CSR, v); chk("R11 clear done", (v >> B_CLR) & 1, 0);

        // R11 sync=1 with freeze
        prep(0, 0, 255, 0, 0);
        wr(A_CNT, 30);
        freeze = 1'b1;
        wr(A_CFG, cfg(1, 0, 0, 1, 0));
        idle(2);
        rd(A_CNT, v); chk("R11 frozen count", v, 30);
        wr(A_CSR, 1 << B_CAPT);
        idle(2);
        rd(A_CSR, v); chk("R11 capt waits in freeze", (v >> B_CAPT) & 1, 1);
        rd(A_CAP, v); chk("R11 capture not yet", v, 7);
        freeze = 1'b0;
        idle(1);
        rd(A_CAP, v); chk("R11 capture on resume", v, 30);
        rd(A_CSR, v); chk("R10 flag after resume", (v >> B_CAPF) & 1, 1);

        // R11 sync=0 with enable off acts at once
        wr(A_CFG, cfg(0, 0, 0, 0, 0));
        wr(A_CNT, 20);
        wr(A_CSR, 1 << B_CLR);
        idle(1);
        rd(A_CNT, v); chk("R11 immediate clear", v, 0);

        // R12 software set and clear of flags
        wr(A_CFG, cfg(0, 0, 0, 0, 7));
        wr(A_CSR, (1 << B_PERF) | (1 << B_ZERF) | (1 << B_CAPF));
        chk("R12 forced irqs", int'({irq_per, irq_zer, irq_cap}), 7);
        wr(A_CSR, 1 << B_ZERF);
        chk("R12 cleared irqs", int'({irq_per, irq_zer, irq_cap}), 2);
        wr(A_CSR, 0);
        rd(A_CSR, v); chk("R12 all flags cleared", (v >> B_PERF) & 7, 0);

        summary();
        $finish;
    end
endmodule